// File: doc/BRIEF.md
# Execute Unit with Condition Logic

This block is the execute stage of a 64-bit single-cycle processor. Each cycle it receives the decoded opcode and function nibbles together with the two register operands and the immediate word. It picks the two adder/logic-unit inputs for that instruction class, picks the operation, and produces the result word. The result serves as an arithmetic value, a memory address or an updated stack pointer.

A three-flag register (zero, sign, signed overflow) is written at the rising clock edge, and only by arithmetic instructions. From the stored flags and the function nibble the block computes a condition bit, which later logic uses for branching. The same bit cancels the destination-register write of a conditional move. Memory, next-PC selection and the register file are outside this block.

Results follow the inputs within the same cycle. The block has no valid/ready interface and no back-pressure, because every cycle carries exactly one instruction and the stage cannot stall. The only state is the flag register.

Top module: `exec_unit`

## Requirements
- R1: With opcode 6 (arithmetic), the result is opnd_b OP opnd_a, where function 0 = add, 1 = subtract (opnd_b - opnd_a), 2 = bitwise AND, 3 = bitwise XOR.
- R2: With opcode 4 (store) or 5 (load), the result is opnd_b + const_w. With opcode 3 (immediate move), the result is const_w.
- R3: With opcode 10 (push) or 8 (call), the result is opnd_b - 8. With opcode 11 (pop) or 9 (return), the result is opnd_b + 8.
- R4: With opcode 2 (register/conditional move), the result is opnd_a. With opcodes 0, 1, 7 and 12 to 15, the result is 0.
- R5: Opcode 6 loads the flags at the rising edge: Z = (result == 0), S = result bit 63, O = signed overflow for add and subtract and 0 for AND and XOR.
- R6: cond_true is computed from the stored flags and op_fn. The codes are: 0 always, 1 (S^O)|Z, 2 S^O, 3 Z, 4 !Z, 5 !(S^O), 6 !(S^O)&!Z. Codes 7 to 15 give 0.
- R7: cond_true in a given cycle uses the flags stored before that cycle's own update.
- R8: With opcode 2 and cond_true = 0, dest_out is 4'hF. In every other case dest_out equals dest_in.
- R9: Reset (rst_n low, asynchronous) sets the flags to Z=1, S=0, O=0. Arithmetic instructions presented during reset do not load the flags.
- R10: Any opcode other than 6 leaves the flags unchanged.
- R11: Arithmetic instructions with function codes 4 to 15 add, and set the flags as for an add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Instruction opcode nibble |
| op_fn | input | 4 | Instruction function nibble |
| opnd_a | input | 64 | First register operand |
| opnd_b | input | 64 | Second register operand |
| const_w | input | 64 | Immediate word |
| dest_in | input | 4 | Requested destination register ID |
| result | output | 64 | Operation result |
| cond_true | output | 1 | Evaluated condition |
| dest_out | output | 4 | Destination ID after conditional-move cancel |

## Verification
result, cond_true and dest_out are combinational, so they are due in the same cycle the inputs are applied. The bench drives inputs just after a rising edge and samples these outputs at the following falling edge. A flag update appears one rising edge after its arithmetic instruction, and only through cond_true. Each check of flag effects is therefore made in a later row, after that edge. Checks made on an arithmetic row itself expect the flags left by the row before.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam logic [3:0] OPC_HALT   = 4'h0;
  localparam logic [3:0] OPC_NOP    = 4'h1;
  localparam logic [3:0] OPC_MOVE   = 4'h2;
  localparam logic [3:0] OPC_IMOV   = 4'h3;
  localparam logic [3:0] OPC_STORE  = 4'h4;
  localparam logic [3:0] OPC_LOAD   = 4'h5;
  localparam logic [3:0] OPC_ARITH  = 4'h6;
  localparam logic [3:0] OPC_BRANCH = 4'h7;
  localparam logic [3:0] OPC_CALL   = 4'h8;
  localparam logic [3:0] OPC_RET    = 4'h9;
  localparam logic [3:0] OPC_PUSH   = 4'hA;
  localparam logic [3:0] OPC_POP    = 4'hB;
  localparam logic [3:0] REG_NONE   = 4'hF;

  typedef enum logic [1:0] {FN_ADD = 2'd0, FN_SUB = 2'd1, FN_AND = 2'd2, FN_XOR = 2'd3} alu_fn_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel
  import exu_pkg::*;
#(
  parameter int W    = 64,
  parameter int STEP = 8
) (
  input  logic [3:0]   op_code,
  input  logic [3:0]   op_fn,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] const_w,
  output logic [W-1:0] alu_a,
  output logic [W-1:0] alu_b,
  output alu_fn_e      alu_fn,
  output logic         flag_load
);
  localparam logic [W-1:0] STEP_UP   = W'(STEP);
  localparam logic [W-1:0] STEP_DOWN = '0 - STEP_UP;

  always_comb begin
    case (op_code)
      OPC_MOVE, OPC_ARITH:            alu_a = opnd_a;
      OPC_IMOV, OPC_STORE, OPC_LOAD:  alu_a = const_w;
      OPC_CALL, OPC_PUSH:             alu_a = STEP_DOWN;
      OPC_RET, OPC_POP:               alu_a = STEP_UP;
      default:                        alu_a = '0;
    endcase
  end

  always_comb begin
    case (op_code)
      OPC_STORE, OPC_LOAD, OPC_ARITH,
      OPC_CALL, OPC_RET, OPC_PUSH, OPC_POP: alu_b = opnd_b;
      default:                              alu_b = '0;
    endcase
  end

  always_comb begin
    alu_fn = FN_ADD;
    if (op_code == OPC_ARITH && op_fn[3:2] == 2'b00) alu_fn = alu_fn_e'(op_fn[1:0]);
  end

  assign flag_load = (op_code == OPC_ARITH);
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] alu_a,
  input  logic [W-1:0] alu_b,
  input  alu_fn_e      alu_fn,
  output logic [W-1:0] alu_y,
  output flags_t       flags_nxt
);
  localparam int MSB = W - 1;

  logic ovf;

  always_comb begin
    ovf = 1'b0;
    case (alu_fn)
      FN_ADD: begin
        alu_y = alu_b + alu_a;
        ovf   = (alu_a[MSB] == alu_b[MSB]) && (alu_y[MSB] != alu_b[MSB]);
      end
      FN_SUB: begin
        alu_y = alu_b - alu_a;
        ovf   = (alu_a[MSB] != alu_b[MSB]) && (alu_y[MSB] != alu_b[MSB]);
      end
      FN_AND:  alu_y = alu_b & alu_a;
      default: alu_y = alu_b ^ alu_a;
    endcase
  end

  assign flags_nxt = '{zf: (alu_y == '0), sf: alu_y[MSB], of: ovf};
endmodule

// File: rtl/exu_cond.sv
module exu_cond
  import exu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flag_load,
  input  flags_t     flags_nxt,
  input  logic [3:0] op_fn,
  output flags_t     flags_q,
  output logic       cond_true
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= FLAGS_RESET;
    else if (flag_load) flags_q <= flags_nxt;
  end

  logic lt;
  assign lt = flags_q.sf ^ flags_q.of;

  always_comb begin
    case (op_fn)
      4'd0:    cond_true = 1'b1;
      4'd1:    cond_true = lt | flags_q.zf;
      4'd2:    cond_true = lt;
      4'd3:    cond_true = flags_q.zf;
      4'd4:    cond_true = !flags_q.zf;
      4'd5:    cond_true = !lt;
      4'd6:    cond_true = !lt && !flags_q.zf;
      default: cond_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exu_pkg::*;
#(
  parameter int W    = 64,
  parameter int STEP = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_code,
  input  logic [3:0]   op_fn,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] const_w,
  input  logic [3:0]   dest_in,
  output logic [W-1:0] result,
  output logic         cond_true,
  output logic [3:0]   dest_out
);
  logic [W-1:0] alu_a, alu_b;
  alu_fn_e      alu_fn;
  logic         flag_load;
  flags_t       flags_nxt, flags_q;

  exu_operand_sel #(.W(W), .STEP(STEP)) sel_i (
    .op_code(op_code), .op_fn(op_fn), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .const_w(const_w), .alu_a(alu_a), .alu_b(alu_b), .alu_fn(alu_fn),
    .flag_load(flag_load)
  );

  exu_alu #(.W(W)) alu_i (
    .alu_a(alu_a), .alu_b(alu_b), .alu_fn(alu_fn),
    .alu_y(result), .flags_nxt(flags_nxt)
  );

  exu_cond cond_i (
    .clk(clk), .rst_n(rst_n), .flag_load(flag_load), .flags_nxt(flags_nxt),
    .op_fn(op_fn), .flags_q(flags_q), .cond_true(cond_true)
  );

  assign dest_out = (op_code == OPC_MOVE && !cond_true) ? REG_NONE : dest_in;
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk #(
  parameter int W    = 64,
  parameter int STEP = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_code,
  input logic [3:0]   op_fn,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result,
  input logic         cond_true,
  input logic [3:0]   dest_in,
  input logic [3:0]   dest_out,
  input logic [2:0]   flags_q
);
  localparam logic [W-1:0] STEP_UP = W'(STEP);

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code != 4'h6) |=> $stable(flags_q));

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'h6) |=> (flags_q[2] == ($past(result) == '0)));

  a_r5_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'h6) |=> (flags_q[1] == $past(result[W-1])));

  a_r8_dest_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'h2 && !cond_true) |-> (dest_out == 4'hF));

  a_r8_dest_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code != 4'h2 || cond_true) |-> (dest_out == dest_in));

  a_r3_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'hA || op_code == 4'h8) |-> (result == opnd_b - STEP_UP));

  a_r3_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'hB || op_code == 4'h9) |-> (result == opnd_b + STEP_UP));

  a_r6_always_true: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fn == 4'd0) |-> cond_true);

  a_r6_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fn > 4'd6) |-> !cond_true);
endmodule

bind exec_unit exec_unit_chk #(.W(W), .STEP(STEP)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_fn(op_fn), .opnd_b(opnd_b),
  .result(result), .cond_true(cond_true), .dest_in(dest_in), .dest_out(dest_out),
  .flags_q(flags_q)
);

// File: tb/exec_unit_tb_top.sv
module exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_code = 4'h1, op_fn = 4'h0, dest_in = 4'hF;
  logic [63:0] opnd_a = '0, opnd_b = '0, const_w = '0;
  logic [63:0] result;
  logic        cond_true;
  logic [3:0]  dest_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_fn(op_fn),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .const_w(const_w), .dest_in(dest_in),
    .result(result), .cond_true(cond_true), .dest_out(dest_out)
  );

  typedef struct packed {
    logic [3:0]  ic;
    logic [3:0]  fn;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] c;
    logic [3:0]  din;
    logic [63:0] ev;
    logic        ec;
    logic [3:0]  ed;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  // Flag state noted after each arithmetic row (Z S O).
  localparam vec_t TBL [NV] = '{
    '{4'h7, 4'h3, 64'h0, 64'h0, 64'h0, 4'h3, 64'h0, 1'b1, 4'h3, 8'd6},   // R6 e after reset
    '{4'h6, 4'h0, 64'h5, 64'h7, 64'h0, 4'h1, 64'hC, 1'b1, 4'h1, 8'd1},   // R1 add -> 000
    '{4'h7, 4'h4, 64'h0, 64'h0, 64'h0, 4'h3, 64'h0, 1'b1, 4'h3, 8'd6},   // R6 ne
    '{4'h6, 4'h1, 64'h9, 64'h4, 64'h0, 4'h1, 64'hFFFF_FFFF_FFFF_FFFB, 1'b0, 4'h1, 8'd7}, // R7 le on old flags -> 010
    '{4'h2, 4'h2, 64'h55, 64'h0, 64'h0, 4'h2, 64'h55, 1'b1, 4'h2, 8'd8}, // R8 cmov taken
    '{4'h2, 4'h5, 64'h66, 64'h0, 64'h0, 4'h2, 64'h66, 1'b0, 4'hF, 8'd8}, // R8 cmov cancelled
    '{4'h6, 4'h2, 64'hF0, 64'h0F, 64'h0, 4'h1, 64'h0, 1'b1, 4'h1, 8'd1}, // R1 and -> 100
    '{4'h7, 4'h6, 64'h0, 64'h0, 64'h0, 4'h3, 64'h0, 1'b0, 4'h3, 8'd5},   // R5 zero flag seen
    '{4'h7, 4'h1, 64'h0, 64'h0, 64'h0, 4'h3, 64'h0, 1'b1, 4'h3, 8'd6},   // R6 le
    '{4'h6, 4'h3, 64'hFF00, 64'h0FF0, 64'h0, 4'h1, 64'hF0F0, 1'b1, 4'h1, 8'd1}, // R1 xor -> 000
    '{4'h6, 4'h0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 4'h1, 64'h8000_0000_0000_0000, 1'b1, 4'h1, 8'd1}, // -> 011
    '{4'h7, 4'h5, 64'h0, 64'h0, 64'h0, 4'h3, 64'h0, 1'b1, 4'h3, 8'd5},   // R5 overflow seen
    '{4'h7, 4'h2, 64'h0, 64'h0, 64'h0, 4'h3, 64'h0, 1'b0, 4'h3, 8'd5},
    '{4'hA, 4'h0, 64'h7, 64'h100, 64'h0, 4'h4, 64'hF8, 1'b1, 4'h4, 8'd3},  // R3 push
    '{4'h8, 4'h0, 64'h0, 64'h40, 64'h0, 4'h4, 64'h38, 1'b1, 4'h4, 8'd3},   // R3 call
    '{4'hB, 4'h0, 64'h3, 64'h100, 64'h0, 4'h4, 64'h108, 1'b1, 4'h4, 8'd3}, // R3 pop
    '{4'h9, 4'h0, 64'h0, 64'h200, 64'h0, 4'h4, 64'h208, 1'b1, 4'h4, 8'd3}, // R3 return
    '{4'h4, 4'h0, 64'h5, 64'h1000, 64'h24, 4'hF, 64'h1024, 1'b1, 4'hF, 8'd2}, // R2 store
    '{4'h5, 4'h0, 64'h0, 64'h10, 64'hFFFF_FFFF_FFFF_FFF0, 4'hF, 64'h0, 1'b1, 4'hF, 8'd2}, // R2 load
    '{4'h3, 4'h0, 64'h0, 64'h99, 64'hABCD, 4'h6, 64'hABCD, 1'b1, 4'h6, 8'd2}, // R2 immediate
    '{4'h2, 4'h0, 64'h77, 64'h12, 64'h34, 4'h5, 64'h77, 1'b1, 4'h5, 8'd4},    // R4 move
    '{4'h1, 4'h0, 64'h11, 64'h22, 64'h33, 4'hF, 64'h0, 1'b1, 4'hF, 8'd4},     // R4 nop
    '{4'h7, 4'h5, 64'h0, 64'h0, 64'h0, 4'h3, 64'h0, 1'b1, 4'h3, 8'd10},  // R10 flags still 011
    '{4'h6, 4'h1, 64'h1, 64'h8000_0000_0000_0000, 64'h0, 4'h1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 4'h1, 8'd5}, // -> 001
    '{4'h7, 4'h2, 64'h0, 64'h0, 64'h0, 4'h3, 64'h0, 1'b1, 4'h3, 8'd5},   // R5 sub overflow seen
    '{4'h6, 4'h5, 64'h2, 64'h3, 64'h0, 4'h1, 64'h5, 1'b0, 4'h1, 8'd11},  // R11 -> 000
    '{4'h7, 4'h6, 64'h0, 64'h0, 64'h0, 4'h3, 64'h0, 1'b1, 4'h3, 8'd6},   // R6 g
    '{4'h7, 4'h8, 64'h0, 64'h0, 64'h0, 4'h3, 64'h0, 1'b0, 4'h3, 8'd6}    // R6 invalid code
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] ic, input logic [3:0] fn, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] c, input logic [3:0] din);
    @(posedge clk);
    #1;
    op_code = ic; op_fn = fn; opnd_a = a; opnd_b = b; const_w = c; dest_in = din;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: reset flags Z=1 S=0 O=0
    apply(4'h7, 4'h4, '0, '0, '0, 4'h3);
    chk(cond_true == 1'b0, "R9 ne after reset", 64'(cond_true), 64'h0);
    apply(4'h7, 4'h2, '0, '0, '0, 4'h3);
    chk(cond_true == 1'b0, "R9 l after reset", 64'(cond_true), 64'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      v = TBL[i];
      apply(v.ic, v.fn, v.a, v.b, v.c, v.din);
      tg = $sformatf("R%0d row %0d", v.req, i);
      chk(result == v.ev, {tg, " result"}, result, v.ev);
      chk(cond_true == v.ec, {tg, " cond"}, 64'(cond_true), 64'(v.ec));
      chk(dest_out == v.ed, {tg, " dest"}, 64'(dest_out), 64'(v.ed));
    end

    // R9: mid-run reset restores Z=1 and blocks loads while asserted
    apply(4'h6, 4'h1, 64'h5, 64'h3, '0, 4'h1);   // sets S=1, Z=0
    apply(4'h7, 4'h3, '0, '0, '0, 4'h3);
    chk(cond_true == 1'b0, "R5 e before reset", 64'(cond_true), 64'h0);
    #1 rst_n = 1'b0;
    #1;
    chk(cond_true == 1'b1, "R9 e during reset", 64'(cond_true), 64'h1);
    apply(4'h6, 4'h0, 64'h1, 64'h1, '0, 4'h1);   // would clear Z if loaded
    @(posedge clk);
    #1 rst_n = 1'b1;
    op_code = 4'h7; op_fn = 4'h3;
    @(negedge clk);
    chk(cond_true == 1'b1, "R9 no load in reset", 64'(cond_true), 64'h1);

    finish_run();
  end
endmodule